// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block takes a set of external interrupt lines and hands each one to an internal interrupt controller as an active-high, level-style request. Software sets the trigger of each line at run time. A line can be level-sensitive, either active-high or active-low. It can also be edge-sensitive, on either the rising or the falling edge. Edge events are held in a sticky pending bit until software clears them with a write-one strobe. A per-line mask gates every request. Separate write-one strobes unmask and mask lines.

Each external input first passes through a two-flop synchroniser. After that comes edge detection or level comparison. Software reaches the block over a simple synchronous register bus with address, write enable, write data and read data. Only the low `NUM_LINES` bits of the trigger-select register can be written. Writing all ones to it and reading it back therefore tells software how many lines exist.

Top module: `ext_irq_cond`

## Requirements
- R1: Each `irq_req` bit is an active-high level. It is high exactly when the line is unmasked and its condition holds. In edge mode the condition is the pending bit. In level mode it is the synchronised input matching the selected level. The output is registered, so it follows a change of those terms by one cycle.
- R2: The trigger-select register (offset 0x00) has one bit per line: 1 selects level sensitivity and 0 selects edge sensitivity. A line in level mode never sets its pending bit.
- R3: The edge-polarity register (offset 0x04) has one bit per line. 1 latches rising edges and 0 latches falling edges of the synchronised input.
- R4: The level-polarity register (offset 0x08) has one bit per line. 1 makes a high input active and 0 makes a low input active.
- R5: Writing 1 to a bit at the unmask strobe (offset 0x0C) unmasks that line. Writing 1 to a bit at the mask strobe (offset 0x10) masks it. Zero bits change nothing. The mask state reads at offset 0x14, with 1 meaning unmasked.
- R6: Writing 1 to a bit at the event-clear strobe (offset 0x18) drops that line's pending bit. Zero bits leave pending bits alone. Pending state reads at offset 0x1C.
- R7: If a new edge is detected in the same cycle as a clear write to that line, the pending bit stays set.
- R8: Masking a line forces its request low but keeps its pending bit. Unmasking it again raises the request.
- R9: Bits of the trigger-select register at and above `NUM_LINES` cannot be written and read as 0.
- R10: The three configuration registers read back what was written. Read data is registered: it shows the register at `bus_addr` one cycle after the address is applied. Unmapped offsets read as 0.
- R11: After reset all lines are masked and in edge mode on the falling edge, all pending bits are 0, and all requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ext_lines | input | NUM_LINES | Asynchronous external interrupt inputs |
| irq_req | output | NUM_LINES | Active-high level requests to the interrupt controller |

## Verification
The edge-latch path and the event-clear strobe can both act on one pending bit in the same clock edge. The bench counts the synchroniser stages to place a clear write on exactly the edge where a fresh rising edge sets the bit. It then reads the pending register and expects the bit to have survived. Random traffic mixes input toggles, configuration writes and strobes. After each step it compares requests, mask and pending state with a model held in the bench.

// File: rtl/eic_pkg.sv
package eic_pkg;
  // Register byte offsets
  localparam int unsigned OFF_TRIG   = 32'h00;
  localparam int unsigned OFF_EPOL   = 32'h04;
  localparam int unsigned OFF_LPOL   = 32'h08;
  localparam int unsigned OFF_UNMASK = 32'h0C;
  localparam int unsigned OFF_MASK   = 32'h10;
  localparam int unsigned OFF_MSTATE = 32'h14;
  localparam int unsigned OFF_CLR    = 32'h18;
  localparam int unsigned OFF_PEND   = 32'h1C;

  typedef struct packed {
    logic trig_level;
    logic edge_rise;
    logic lvl_high;
    logic unmasked;
  } line_cfg_t;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/eic_line.sv
module eic_line
  import eic_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sync_in,
  input  line_cfg_t cfg,
  input  logic      clr_strobe,
  output logic      pend,
  output logic      req
);
  logic prev_q;
  logic rise, fall, hit, lvl_match, cond;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_in;
  end

  assign rise      = sync_in & ~prev_q;
  assign fall      = ~sync_in & prev_q;
  assign hit       = ~cfg.trig_level & (cfg.edge_rise ? rise : fall);
  assign lvl_match = ~(sync_in ^ cfg.lvl_high);

  // A fresh edge wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst)        pend <= 1'b0;
    else if (hit)   pend <= 1'b1;
    else if (clr_strobe) pend <= 1'b0;
  end

  assign cond = cfg.trig_level ? lvl_match : pend;

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= cfg.unmasked & cond;
  end
endmodule

// File: rtl/eic_regfile.sv
module eic_regfile
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] pend_vec,
  output logic [NUM_LINES-1:0] trig_q,
  output logic [NUM_LINES-1:0] epol_q,
  output logic [NUM_LINES-1:0] lpol_q,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] clr_vec
);
  localparam int PAD = DATA_W - NUM_LINES;

  logic [NUM_LINES-1:0] wbits;
  logic sel_trig, sel_epol, sel_lpol, sel_unmask, sel_mask, sel_clr;
  logic [NUM_LINES-1:0] rd_next;

  assign wbits      = bus_wdata[NUM_LINES-1:0];
  assign sel_trig   = bus_we && (bus_addr == OFF_TRIG[ADDR_W-1:0]);
  assign sel_epol   = bus_we && (bus_addr == OFF_EPOL[ADDR_W-1:0]);
  assign sel_lpol   = bus_we && (bus_addr == OFF_LPOL[ADDR_W-1:0]);
  assign sel_unmask = bus_we && (bus_addr == OFF_UNMASK[ADDR_W-1:0]);
  assign sel_mask   = bus_we && (bus_addr == OFF_MASK[ADDR_W-1:0]);
  assign sel_clr    = bus_we && (bus_addr == OFF_CLR[ADDR_W-1:0]);

  assign clr_vec = sel_clr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= '0;
      epol_q <= '0;
      lpol_q <= '0;
      mask_q <= '0;
    end else begin
      if (sel_trig)   trig_q <= wbits;
      if (sel_epol)   epol_q <= wbits;
      if (sel_lpol)   lpol_q <= wbits;
      if (sel_unmask) mask_q <= mask_q | wbits;
      if (sel_mask)   mask_q <= mask_q & ~wbits;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_TRIG[ADDR_W-1:0]:   rd_next = trig_q;
      OFF_EPOL[ADDR_W-1:0]:   rd_next = epol_q;
      OFF_LPOL[ADDR_W-1:0]:   rd_next = lpol_q;
      OFF_MSTATE[ADDR_W-1:0]: rd_next = mask_q;
      OFF_PEND[ADDR_W-1:0]:   rd_next = pend_vec;
      default:                rd_next = '0;
    endcase
  end

  generate
    if (PAD > 0) begin : g_pad
      always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= {{PAD{1'b0}}, rd_next};
      end
    end else begin : g_nopad
      always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_next;
      end
    end
  endgenerate
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import eic_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] ext_lines,
  output logic [NUM_LINES-1:0] irq_req
);
  logic [NUM_LINES-1:0] synced;
  logic [NUM_LINES-1:0] trig_q, epol_q, lpol_q, mask_q, clr_vec, pend_vec;

  eic_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_lines), .sync_out(synced)
  );

  eic_regfile #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_vec(pend_vec),
    .trig_q(trig_q), .epol_q(epol_q), .lpol_q(lpol_q), .mask_q(mask_q),
    .clr_vec(clr_vec)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_LINES; i++) begin : g_line
      line_cfg_t cfg;
      assign cfg.trig_level = trig_q[i];
      assign cfg.edge_rise  = epol_q[i];
      assign cfg.lvl_high   = lpol_q[i];
      assign cfg.unmasked   = mask_q[i];
      eic_line u_line (
        .clk(clk), .rst(rst), .sync_in(synced[i]), .cfg(cfg),
        .clr_strobe(clr_vec[i]), .pend(pend_vec[i]), .req(irq_req[i])
      );
    end
  endgenerate
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_LINES-1:0] irq_req,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] pend_vec,
  input logic [NUM_LINES-1:0] clr_vec
);
  localparam logic [DATA_W-1:0] LOW_ONES = DATA_W'((64'(1) << NUM_LINES) - 1);

  // R1
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req & ~$past(mask_q)) == '0);

  // R6
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_vec) & ~$past(clr_vec) & ~pend_vec) == '0);

  // R9
  trig_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == '0) |-> ((bus_rdata & ~LOW_ONES) == '0));

  // R11
  reset_mask_chk: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == '0 && pend_vec == '0));

  // R8
  mask_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_vec) & ~$past(clr_vec) & ~$past(mask_q) & ~pend_vec) == '0);
endmodule

bind ext_irq_cond eic_checker #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq_req(irq_req), .mask_q(mask_q), .pend_vec(pend_vec), .clr_vec(clr_vec)
);

// File: tb/ext_irq_cond_bench.sv
module ext_irq_cond_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int DW = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NL-1:0] ext_lines = '0;
  logic [NL-1:0] irq_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [NL-1:0] m_trig = '0, m_epol = '0, m_lpol = '0, m_mask = '0, m_pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_cond #(.NUM_LINES(NL), .DATA_W(DW), .ADDR_W(AW)) u_ext_irq_cond (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_lines(ext_lines), .irq_req(irq_req)
  );

  function automatic logic [NL-1:0] exp_req();
    return m_mask & ((m_trig & ~(ext_lines ^ m_lpol)) | (~m_trig & m_pend));
  endfunction

  function automatic logic [NL-1:0] edge_hits(logic [NL-1:0] o, logic [NL-1:0] n);
    return ~m_trig & ((m_epol & ~o & n) | (~m_epol & o & ~n));
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_ext(logic [NL-1:0] n);
    m_pend = m_pend | edge_hits(ext_lines, n);
    @(negedge clk);
    ext_lines = n;
    settle();
  endtask

  task automatic check_all(string req);
    logic [DW-1:0] v;
    check(req, DW'(irq_req), DW'(exp_req()));
    rd(8'h14, v); check(req, v, DW'(m_mask));
    rd(8'h1C, v); check(req, v, DW'(m_pend));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check("R11 req", DW'(irq_req), '0);
    rd(8'h14, v); check("R11 mask", v, '0);
    rd(8'h1C, v); check("R11 pend", v, '0);
    rd(8'h00, v); check("R11 trig", v, '0);
    rd(8'h04, v); check("R11 epol", v, '0);

    // R9 line count discovery
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R9 trig width", v, 32'h0000_00FF);
    // R10 readback and unmapped
    wr(8'h04, 32'h0000_00A5); m_epol = 8'hA5;
    rd(8'h04, v); check("R10 epol", v, 32'hA5);
    wr(8'h08, 32'h0000_003C); m_lpol = 8'h3C;
    rd(8'h08, v); check("R10 lpol", v, 32'h3C);
    rd(8'h24, v); check("R10 unmapped", v, '0);
    wr(8'h00, 32'h0); m_trig = '0;
    wr(8'h04, 32'hFF); m_epol = 8'hFF;
    settle();

    // R5 enable/disable strobes
    wr(8'h0C, 32'h0F); m_mask = 8'h0F;
    wr(8'h0C, 32'h00);
    wr(8'h10, 32'h00);
    rd(8'h14, v); check("R5 zeros keep", v, 32'h0F);
    wr(8'h10, 32'h03); m_mask = 8'h0C;
    rd(8'h14, v); check("R5 mask", v, 32'h0C);
    wr(8'h0C, 32'hF3); m_mask = 8'hFF;

    // R3 rising edge on line 1
    set_ext(8'h02);
    check_all("R3");
    // R6 zero clear does nothing, one clears
    wr(8'h18, 32'h00); settle(); check_all("R6 zero");
    wr(8'h18, 32'h02); m_pend = 8'h00; settle(); check_all("R6 clear");

    // R8 masking keeps pending
    set_ext(8'h00);
    set_ext(8'h01);
    wr(8'h10, 32'h01); m_mask = 8'hFE; settle(); check_all("R8 masked");
    wr(8'h0C, 32'h01); m_mask = 8'hFF; settle(); check_all("R8 unmask");
    wr(8'h18, 32'h01); m_pend = 8'h00; settle();

    // R7 edge and clear on the same edge (line 2, rising)
    @(negedge clk); ext_lines = 8'h05;
    @(negedge clk);
    @(negedge clk); bus_addr = 8'h18; bus_we = 1'b1; bus_wdata = 32'h04;
    @(negedge clk); bus_we = 1'b0;
    m_pend = 8'h04;
    settle();
    rd(8'h1C, v); check("R7 edge wins", v, 32'h04);
    wr(8'h18, 32'hFF); m_pend = '0; settle();

    // R2 / R4 level mode on lines 4..7
    wr(8'h00, 32'hF0); m_trig = 8'hF0;
    settle(); check_all("R2 level");
    set_ext(8'h35); check_all("R4 level");
    set_ext(8'hC5); check_all("R1 level follow");

    // random traffic
    for (int it = 0; it < 300; it++) begin
      int unsigned op = $urandom_range(0, 6);
      logic [NL-1:0] r = NL'($urandom);
      case (op)
        0: begin wr(8'h00, DW'(r)); m_trig = r; end
        1: begin wr(8'h04, DW'(r)); m_epol = r; end
        2: begin wr(8'h08, DW'(r)); m_lpol = r; end
        3: begin wr(8'h0C, DW'(r)); m_mask = m_mask | r; end
        4: begin wr(8'h10, DW'(r)); m_mask = m_mask & ~r; end
        5: begin wr(8'h18, DW'(r)); m_pend = m_pend & ~r; end
        default: ;
      endcase
      settle();
      if (op >= 5) set_ext(r ^ ext_lines ^ NL'($urandom));
      check_all("R1 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule